// File: doc/BRIEF.md
# Pulsed Charge Cycle Generator

This block produces the repeating current pattern for a pulsed battery charger. Each cycle is a charge pulse, an optional conditioning discharge pulse, a rest interval with no current, and a quiet acquisition window. During the window the block issues one strobe so that an external converter can take a single battery-voltage sample. The stage input selects the pattern. Soft-start lengthens the charge pulse over a fixed number of cycles. Fast charge uses the full pulse. Topping appends an idle delay after every cycle, and maintenance appends four times that delay.

Two rate groups set the cycle period and the discharge width. All durations are counted in milliseconds, using a prescaler that derives a millisecond tick from the clock. The stage, rate group and conditioning strap are sampled only at a cycle boundary, so a pulse is never cut short. Converting the sample and deciding when to end a stage are left to the surrounding logic.

Top module: `pulse_cycle_gen`

## Requirements
- R1: Each cycle drives `chg_en_o` first, then an idle gap of (full width − current width) ms, then the discharge slot, then REST_MS ms and ACQ_MS ms with both drives low. `chg_en_o` rises only at a cycle boundary, and the two drives are never high together.
- R2: With `rate_i`=0 the base cycle is CYC_A_MS ms and the discharge slot is DIS_A_MS ms. With `rate_i`=1 they are CYC_B_MS ms and DIS_B_MS ms.
- R3: The full charge pulse is the base cycle minus the discharge slot, REST_MS and ACQ_MS. Fast charge (`stage_i`=2) uses it in every cycle.
- R4: Soft-start (`stage_i`=1) begins with init = floor(full/5). Its k-th cycle (k from 0) drives init + floor(k·(full−init)/RAMP_N) ms, which is exactly full from k = RAMP_N onward. The cycle period stays the base cycle throughout.
- R5: The ramp restarts at init when soft-start begins after any other stage or after idle, and when the rate group changes while soft-start continues.
- R6: Every cycle gives exactly one one-clock `acq_stb_o`, on the last clock of the acquisition window. `cyc_done_o` is a one-clock pulse on the last clock of the cycle.
- R7: Topping (`stage_i`=3) appends TOP_DLY_MS ms with no current after the acquisition window. Maintenance (`stage_i`=4) appends 4·TOP_DLY_MS ms. The pulse shape is unchanged.
- R8: With `cond_en_i` low, `dis_en_o` stays low and every other timing is unchanged.
- R9: `stage_i`, `rate_i` and `cond_en_i` take effect only at a cycle boundary. A stage code of 0 or 5..7 lets the running cycle finish, after which the block idles with all outputs low.
- R10: While reset is held, and afterwards until a valid stage code arrives, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stage_i | input | 3 | 0 off, 1 soft-start, 2 fast, 3 topping, 4 maintenance, 5..7 off |
| rate_i | input | 1 | Rate group: 0 short cycle, 1 long cycle |
| cond_en_i | input | 1 | Enables the conditioning discharge pulse |
| chg_en_o | output | 1 | Turns on the external charge source |
| dis_en_o | output | 1 | Turns on the external discharge sink |
| acq_stb_o | output | 1 | One-clock sample strobe in the acquisition window |
| cyc_done_o | output | 1 | One-clock pulse on the last clock of each cycle |

## Verification
The bench builds the block with a 2-clock millisecond tick, base cycles of 40 and 80 ms, discharge slots of 2 and 4 ms, a 10 ms topping delay and an 8-cycle ramp. These values put a complete soft-start ramp, every stage and both rate groups within a few thousand clocks. Rate group 0 leaves a remainder of 2 in the ramp division, so the carry path and the exact landing on full width are exercised. Rate group 1 divides evenly.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_CHG, PH_GAP, PH_DIS, PH_REST, PH_ACQ, PH_DLY
  } phase_e;

  localparam logic [2:0] STG_OFF   = 3'd0;
  localparam logic [2:0] STG_SOFT  = 3'd1;
  localparam logic [2:0] STG_FAST  = 3'd2;
  localparam logic [2:0] STG_TOP   = 3'd3;
  localparam logic [2:0] STG_MAINT = 3'd4;
endpackage

// File: rtl/pcg_tick.sv
module pcg_tick #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == LAST);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pcg_ramp.sv
module pcg_ramp #(
  parameter int MSW    = 12,
  parameter int NW     = 7,
  parameter int RAMP_N = 120
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           soft_new,
  input  logic           cont,
  input  logic [MSW-1:0] init_new,
  input  logic [MSW-1:0] inc_new,
  input  logic [NW-1:0]  rem_new,
  input  logic [MSW-1:0] full_new,
  input  logic [MSW-1:0] full_cur,
  output logic [MSW-1:0] w_nxt,
  output logic [MSW-1:0] w_q
);
  logic [MSW-1:0] w_d;
  logic [NW-1:0]  acc_q, acc_d, n_q, n_d;
  logic [NW:0]    sum;
  logic           carry;

  always_comb begin
    w_d   = w_q;
    acc_d = acc_q;
    n_d   = n_q;
    sum   = {1'b0, acc_q} + {1'b0, rem_new};
    carry = sum >= (NW+1)'(RAMP_N);
    if (start) begin
      if (!soft_new) begin
        w_d = full_new; acc_d = '0; n_d = '0;
      end else if (!cont) begin
        w_d = init_new; acc_d = '0; n_d = '0;
      end else if (n_q < NW'(RAMP_N)) begin
        w_d   = w_q + inc_new + MSW'(carry);
        acc_d = carry ? NW'(sum - (NW+1)'(RAMP_N)) : NW'(sum);
        n_d   = n_q + 1'b1;
      end
    end
    w_nxt = w_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0; acc_q <= '0; n_q <= '0;
    end else begin
      w_q <= w_d; acc_q <= acc_d; n_q <= n_d;
    end
  end

  // R4: a continuing ramp never shrinks
  p_ramp_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && soft_new && cont) |=> (w_q >= $past(w_q)));
  // R4: the last ramp step lands on the full width exactly
  p_ramp_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && soft_new && cont && n_q == NW'(RAMP_N - 1)) |=> (w_q == $past(full_cur)));
endmodule

// File: rtl/pcg_seq.sv
module pcg_seq
  import pcg_pkg::*;
#(
  parameter int MSW     = 12,
  parameter int REST_MS = 4,
  parameter int ACQ_MS  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           go,
  input  logic [MSW-1:0] chg_ms,
  input  logic [MSW-1:0] gap_ms,
  input  logic [MSW-1:0] dis_ms,
  input  logic [MSW-1:0] dly_ms,
  output phase_e         phase_o,
  output logic           bnd_o,
  output logic           start_o,
  output logic           acq_stb_o,
  output logic           cyc_done_o
);
  phase_e         phase_q, phase_d;
  logic [MSW-1:0] left_q, left_d;
  logic           last;

  always_comb begin
    last       = tick && (left_q == MSW'(1));
    cyc_done_o = last && ((phase_q == PH_ACQ && dly_ms == '0) || phase_q == PH_DLY);
    acq_stb_o  = last && (phase_q == PH_ACQ);
    bnd_o      = (phase_q == PH_IDLE) || cyc_done_o;
    start_o    = bnd_o && go;
    phase_d    = phase_q;
    left_d     = left_q;
    if (bnd_o) begin
      if (go) begin phase_d = PH_CHG;  left_d = chg_ms; end
      else    begin phase_d = PH_IDLE; left_d = '0;     end
    end else if (last) begin
      case (phase_q)
        PH_CHG: begin
          if (gap_ms != '0) begin phase_d = PH_GAP; left_d = gap_ms; end
          else              begin phase_d = PH_DIS; left_d = dis_ms; end
        end
        PH_GAP:  begin phase_d = PH_DIS;  left_d = dis_ms;          end
        PH_DIS:  begin phase_d = PH_REST; left_d = MSW'(REST_MS);   end
        PH_REST: begin phase_d = PH_ACQ;  left_d = MSW'(ACQ_MS);    end
        PH_ACQ:  begin phase_d = PH_DLY;  left_d = dly_ms;          end
        default: begin phase_d = PH_IDLE; left_d = '0;              end
      endcase
    end else if (tick) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; left_q <= '0;
    end else begin
      phase_q <= phase_d; left_q <= left_d;
    end
  end

  assign phase_o = phase_q;

  // strobe counter kept for the per-cycle check below
  logic [1:0] stb_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          stb_cnt <= '0;
    else if (start_o)                    stb_cnt <= '0;
    else if (acq_stb_o && stb_cnt != 2'd3) stb_cnt <= stb_cnt + 1'b1;
  end

  // R6: exactly one sample strobe in every finished cycle
  p_one_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done_o |-> (acq_stb_o ? (stb_cnt == 2'd0) : (stb_cnt == 2'd1)));
  // R1: discharge slot is entered only from the charge pulse or its gap
  p_dis_after_chg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DIS && $past(phase_q) != PH_DIS) |->
      ($past(phase_q) == PH_CHG || $past(phase_q) == PH_GAP));
endmodule

// File: rtl/pulse_cycle_gen.sv
module pulse_cycle_gen
  import pcg_pkg::*;
#(
  parameter int TICK_DIV   = 1000,
  parameter int CYC_A_MS   = 1100,
  parameter int DIS_A_MS   = 5,
  parameter int CYC_B_MS   = 2200,
  parameter int DIS_B_MS   = 10,
  parameter int REST_MS    = 4,
  parameter int ACQ_MS     = 2,
  parameter int TOP_DLY_MS = 3300,
  parameter int RAMP_N     = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] stage_i,
  input  logic       rate_i,
  input  logic       cond_en_i,
  output logic       chg_en_o,
  output logic       dis_en_o,
  output logic       acq_stb_o,
  output logic       cyc_done_o
);
  localparam int MAXMS  = CYC_A_MS + CYC_B_MS + 4 * TOP_DLY_MS;
  localparam int MSW    = $clog2(MAXMS + 1);
  localparam int NW     = $clog2(RAMP_N + 1);
  localparam int FULL_A = CYC_A_MS - DIS_A_MS - REST_MS - ACQ_MS;
  localparam int FULL_B = CYC_B_MS - DIS_B_MS - REST_MS - ACQ_MS;
  localparam int INIT_A = FULL_A / 5;
  localparam int INIT_B = FULL_B / 5;
  localparam int INC_A  = (FULL_A - INIT_A) / RAMP_N;
  localparam int INC_B  = (FULL_B - INIT_B) / RAMP_N;
  localparam int REM_A  = (FULL_A - INIT_A) % RAMP_N;
  localparam int REM_B  = (FULL_B - INIT_B) % RAMP_N;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // settings sampled at the cycle boundary
  logic [2:0] stage_q, stage_d;
  logic       rate_q, rate_d, strap_q, strap_d;
  logic       bnd, start, tick, go, run, soft_new, cont;
  logic       acq_stb, cyc_done;
  phase_e     phase;
  logic [MSW-1:0] full_new, full_cur, init_new, inc_new, w_nxt, w_q;
  logic [MSW-1:0] gap_ms, dis_ms, dly_ms;
  logic [NW-1:0]  rem_new;

  always_comb begin
    stage_d = bnd ? stage_i   : stage_q;
    rate_d  = bnd ? rate_i    : rate_q;
    strap_d = bnd ? cond_en_i : strap_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stage_q <= STG_OFF; rate_q <= 1'b0; strap_q <= 1'b0;
    end else begin
      stage_q <= stage_d; rate_q <= rate_d; strap_q <= strap_d;
    end
  end

  always_comb begin
    go       = (stage_i == STG_SOFT) || (stage_i == STG_FAST) ||
               (stage_i == STG_TOP)  || (stage_i == STG_MAINT);
    soft_new = (stage_i == STG_SOFT);
    cont     = (stage_q == STG_SOFT) && (rate_q == rate_i) && (phase != PH_IDLE);
    full_new = rate_i ? MSW'(FULL_B) : MSW'(FULL_A);
    init_new = rate_i ? MSW'(INIT_B) : MSW'(INIT_A);
    inc_new  = rate_i ? MSW'(INC_B)  : MSW'(INC_A);
    rem_new  = rate_i ? NW'(REM_B)   : NW'(REM_A);
    full_cur = rate_q ? MSW'(FULL_B) : MSW'(FULL_A);
    dis_ms   = rate_q ? MSW'(DIS_B_MS) : MSW'(DIS_A_MS);
    gap_ms   = full_cur - w_q;
    case (stage_q)
      STG_TOP:   dly_ms = MSW'(TOP_DLY_MS);
      STG_MAINT: dly_ms = MSW'(4 * TOP_DLY_MS);
      default:   dly_ms = '0;
    endcase
    run = (phase != PH_IDLE);
  end

  pcg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .run(run), .tick(tick)
  );

  pcg_ramp #(.MSW(MSW), .NW(NW), .RAMP_N(RAMP_N)) u_ramp (
    .clk(clk), .rst_n(rst_int_n), .start(start), .soft_new(soft_new),
    .cont(cont), .init_new(init_new), .inc_new(inc_new), .rem_new(rem_new),
    .full_new(full_new), .full_cur(full_cur), .w_nxt(w_nxt), .w_q(w_q)
  );

  pcg_seq #(.MSW(MSW), .REST_MS(REST_MS), .ACQ_MS(ACQ_MS)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .go(go),
    .chg_ms(w_nxt), .gap_ms(gap_ms), .dis_ms(dis_ms), .dly_ms(dly_ms),
    .phase_o(phase), .bnd_o(bnd), .start_o(start),
    .acq_stb_o(acq_stb), .cyc_done_o(cyc_done)
  );

  assign chg_en_o   = (phase == PH_CHG);
  assign dis_en_o   = (phase == PH_DIS) && strap_q;
  assign acq_stb_o  = acq_stb;
  assign cyc_done_o = cyc_done;

  // R1: charge drive turns on only at a cycle boundary
  p_chg_at_bnd_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(chg_en_o) |-> $past(bnd));
  // R1: no current while the sample is taken
  p_quiet_acq_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    acq_stb_o |-> (!chg_en_o && !dis_en_o));
  // R9: sampled stage holds for the whole cycle
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bnd |=> $stable(stage_q));
  // R4: the pulse in use never exceeds the full width of its rate group
  p_width_cap_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && !bnd) |-> (w_q <= full_cur));
endmodule

// File: tb/pulse_cycle_gen_tb.sv
module pulse_cycle_gen_tb;
  localparam int DIV = 2;
  localparam int CA = 40, DA = 2, CB = 80, DB = 4;
  localparam int RS = 4, AQ = 2, TD = 10, RN = 8;
  localparam int FA = CA - DA - RS - AQ;
  localparam int FB = CB - DB - RS - AQ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stage = 3'd0;
  logic       rate = 1'b0;
  logic       cond = 1'b0;
  logic       chg_en, dis_en, acq_stb, cyc_done;

  int total = 0;
  int bad = 0;
  int m_chg, m_dis0, m_dis, m_stb, m_nstb, m_per;

  always #2 clk = ~clk;

  pulse_cycle_gen #(
    .TICK_DIV(DIV), .CYC_A_MS(CA), .DIS_A_MS(DA), .CYC_B_MS(CB), .DIS_B_MS(DB),
    .REST_MS(RS), .ACQ_MS(AQ), .TOP_DLY_MS(TD), .RAMP_N(RN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .stage_i(stage), .rate_i(rate), .cond_en_i(cond),
    .chg_en_o(chg_en), .dis_en_o(dis_en), .acq_stb_o(acq_stb), .cyc_done_o(cyc_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int soft_w(input int full, input int k);
    int init = full / 5;
    if (k >= RN) return full;
    return init + (k * (full - init)) / RN;
  endfunction

  // samples one cycle; index 0 is the first negedge after the starting edge
  task automatic measure(input int set_idx, input logic [2:0] set_stage);
    bit done = 0;
    m_chg = 0; m_dis0 = -1; m_dis = 0; m_stb = -1; m_nstb = 0; m_per = -1;
    for (int i = 0; i < 4000 && !done; i++) begin
      @(negedge clk);
      if (chg_en) m_chg++;
      if (dis_en) begin if (m_dis0 < 0) m_dis0 = i; m_dis++; end
      if (acq_stb) begin m_nstb++; m_stb = i; end
      if (cyc_done) begin done = 1; m_per = i + 1; end
      if (i == set_idx) stage = set_stage;
    end
  endtask

  task automatic check_cycle(input string tag, input int w, input int full,
                             input int dis_ms, input bit dis_on, input int base, input int dly);
    check({tag, " R1 R4 charge clocks"}, m_chg, w * DIV);
    check({tag, " R1 R8 discharge start"}, m_dis0, dis_on ? full * DIV : -1);
    check({tag, " R2 R8 discharge clocks"}, m_dis, dis_on ? dis_ms * DIV : 0);
    check({tag, " R6 strobe index"}, m_stb, base * DIV - 1);
    check({tag, " R6 strobe count"}, m_nstb, 1);
    check({tag, " R2 R7 period"}, m_per, (base + dly) * DIV);
  endtask

  task automatic idle_window(input string tag, input int n);
    int act = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      act += int'(chg_en) + int'(dis_en) + int'(acq_stb) + int'(cyc_done);
    end
    check(tag, act, 0);
  endtask

  task automatic t_reset;
    check("R10 outputs in reset", int'(chg_en) + int'(dis_en) + int'(acq_stb) + int'(cyc_done), 0);
    rst_n = 1'b1;
    idle_window("R10 idle after reset", 20);
    stage = 3'd6;
    idle_window("R9 R10 invalid stage code idles", 20);
  endtask

  task automatic t_soft_ramp_a;
    rate = 1'b0; cond = 1'b1; stage = 3'd1;
    for (int k = 0; k <= RN + 1; k++) begin
      measure(-1, 3'd1);
      check_cycle($sformatf("R4 soft A k=%0d", k), soft_w(FA, k), FA, DA, 1'b1, CA, 0);
    end
  endtask

  task automatic t_fast_a_nocond;
    stage = 3'd2; cond = 1'b0;
    measure(-1, 3'd2);
    check_cycle("R3 R8 fast A no conditioning", FA, FA, DA, 1'b0, CA, 0);
  endtask

  task automatic t_topping;
    stage = 3'd3; cond = 1'b1;
    measure(-1, 3'd3);
    check_cycle("R7 topping", FA, FA, DA, 1'b1, CA, TD);
  endtask

  task automatic t_maint;
    stage = 3'd4;
    measure(-1, 3'd4);
    check_cycle("R7 maintenance", FA, FA, DA, 1'b1, CA, 4 * TD);
  endtask

  task automatic t_fast_b;
    stage = 3'd2; rate = 1'b1;
    measure(-1, 3'd2);
    check_cycle("R2 R3 fast B", FB, FB, DB, 1'b1, CB, 0);
  endtask

  task automatic t_soft_restart;
    stage = 3'd1;
    measure(-1, 3'd1);
    check_cycle("R5 soft B restart k=0", soft_w(FB, 0), FB, DB, 1'b1, CB, 0);
    measure(-1, 3'd1);
    check_cycle("R5 soft B k=1", soft_w(FB, 1), FB, DB, 1'b1, CB, 0);
    rate = 1'b0;
    measure(-1, 3'd1);
    check_cycle("R5 rate change restarts ramp", soft_w(FA, 0), FA, DA, 1'b1, CA, 0);
  endtask

  task automatic t_stop_midcycle;
    measure(10, 3'd0);
    check_cycle("R9 stop mid-cycle not truncated", soft_w(FA, 1), FA, DA, 1'b1, CA, 0);
    idle_window("R9 idle after stop", 100);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        stage = 3'd0;
        repeat (3) @(negedge clk);
        t_soft_ramp_a();
        t_fast_a_nocond();
        t_topping();
        t_maint();
        t_fast_b();
        t_soft_restart();
        t_stop_midcycle();
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1..R10 run: actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule